// File: doc/BRIEF.md
# Shared Interrupt Conditioning, Masking and Pin Routing

This block is the front end for a set of shared interrupt lines on their way to the processor cores. Each raw input first passes through a two-stage synchroniser. It is then conditioned by three per-source configuration bits: polarity, trigger mode and both-edge mode. The result becomes a pending bit. An edge-sensed pending bit is latched. A level-sensed one tracks the input.

Software controls the block through a single 32-bit register port. Through it, software can:
- read and write the configuration bits,
- enable and disable sources through separate set and clear words, so no read-modify-write is needed,
- raise or drop an edge-sensed pending bit through a one-word command register,
- give each source a route to one of up to 64 CPU pins, to a non-maskable output, or to both.

Every pending and enabled source drives the outputs it is routed to. The outputs are registered.

Register addresses on the port are word addresses, and the byte offset is four times the word address. The bit-vector registers hold one bit per source, with source n at bit n%32 of word n/32. The words of one register sit at consecutive word addresses.

Top module: `shirq_top`

## Requirements
- R1: After reset, every source reads as active-high (polarity 1) and level-sensed (trigger 0), with both-edge mode off, disabled, not pending and with a zero route word. The pin and NMI outputs are low.
- R2: With trigger 0 (level), the pending bit follows the synchronised input when polarity is 1 and follows its inverse when polarity is 0. It latches nothing.
- R3: With trigger 1 and both-edge 0, a rising input edge sets pending when polarity is 1 and a falling edge sets it when polarity is 0. The other edge does not set it. Once set, the bit stays set until software clears it.
- R4: With trigger 1 and both-edge 1, either edge sets pending. With trigger 0, the both-edge bit has no effect.
- R5: A write to the command word (word address 0x0A0) with a source number in bits 7:0 acts on that source's pending bit. Bit 31 set to 1 sets the bit and bit 31 set to 0 clears it. The command acts only on edge-sensed sources. Numbers at or above the source count change nothing.
- R6: Writing a 1 to a bit of the enable-set words (from 0x0E0) enables that source. Writing a 1 to a bit of the enable-clear words (from 0x0C0) disables it. Zero bits change nothing. The enable state reads back from 0x100.
- R7: Pending state reads from 0x120. The command and enable-set/clear words read as zero.
- R8: The polarity (0x040), trigger (0x060) and both-edge (0x080) words read back as written. Bits for source numbers at or above the source count read as 0.
- R9: The route word of source n is at 0x140+n. Bit 31 routes the source to a CPU pin, bit 30 routes it to NMI, and bits 5:0 select the pin. All other bits read as 0.
- R10: CPU pin p is high one cycle after some source is pending, enabled, routed to a pin and selects p. The NMI output works the same way for NMI-routed sources. A pin number at or above the pin count drives nothing.
- R11: A level input change driven between clock edges shows at its pin after exactly four rising edges, and not after three.
- R12: If an edge event reaches a source's pending logic in the same cycle as a clear command for that source, the event wins and the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Raw shared interrupt lines, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data is valid the cycle after |
| reg_addr | input | 14 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, held between reads |
| cpu_pin | output | NUM_PINS | Routed interrupt outputs to the CPU |
| nmi_out | output | 1 | Non-maskable interrupt output |

## Verification
The hardest case to reach is a clear command that arrives in the very cycle an edge on the same source reaches the pending logic. The edge is only visible there for one cycle, behind two synchroniser stages. To hit it, the bench drives the input between edges, lets exactly two rising edges pass, and places the command write so that it is sampled on the third edge. A readback then shows whether the event survived. The exact four-edge input-to-pin latency is checked with the same edge counting.

// File: rtl/shirq_pkg.sv
// Package: shared constants and types for the shared interrupt front end.
// Assumes word-addressed registers; byte offset = 4 * word address.
package shirq_pkg;

    localparam int ADDR_W      = 14;
    localparam int PIN_FIELD_W = 6;

    // Register regions, selected by word address bits 13:5
    localparam logic [8:0] RGN_POL   = 9'd2;   // 0x040
    localparam logic [8:0] RGN_TRIG  = 9'd3;   // 0x060
    localparam logic [8:0] RGN_DUAL  = 9'd4;   // 0x080
    localparam logic [8:0] RGN_CMD   = 9'd5;   // 0x0A0
    localparam logic [8:0] RGN_CMASK = 9'd6;   // 0x0C0
    localparam logic [8:0] RGN_SMASK = 9'd7;   // 0x0E0
    localparam logic [8:0] RGN_MASK  = 9'd8;   // 0x100
    localparam logic [8:0] RGN_PEND  = 9'd9;   // 0x120

    localparam logic [ADDR_W-1:0] ROUTE_BASE = 14'h140;

    typedef struct packed {
        logic                   to_pin;
        logic                   to_nmi;
        logic [PIN_FIELD_W-1:0] pin;
    } route_t;

endpackage

// File: rtl/shirq_cond.sv
// Module: shirq_cond
// Synchronises raw inputs, detects edges and keeps the pending state.
// Assumes the command set/clear vectors are never both set for one source.
module shirq_cond #(
    parameter int NUM_SRC = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_raw,
    input  logic [NUM_SRC-1:0] pol,
    input  logic [NUM_SRC-1:0] trig,
    input  logic [NUM_SRC-1:0] dual,
    input  logic [NUM_SRC-1:0] cmd_set,
    input  logic [NUM_SRC-1:0] cmd_clr,
    output logic [NUM_SRC-1:0] pend
);

    logic [NUM_SRC-1:0] sync1, sync2, prev;
    logic [NUM_SRC-1:0] active, rise, fall, hit, pend_nxt;

    // Two-stage synchroniser plus a delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
        end else begin
            sync1 <= irq_raw;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    // Polarity-conditioned level and edge events per source
    always_comb begin
        active = sync2 ~^ pol;
        rise   = sync2 & ~prev;
        fall   = ~sync2 & prev;
        hit    = (rise & (pol | dual)) | (fall & (~pol | dual));
    end

    // Next pending: level tracks input; edge latches, an event beats a clear
    always_comb begin
        pend_nxt = (trig & ((pend & ~cmd_clr) | cmd_set | hit)) | (~trig & active);
    end

    // Pending state register
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nxt;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        // R3: a latched edge-sensed bit holds until a clear command
        a_r3_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (trig[i] && pend[i] && !cmd_clr[i]) |=> (pend[i] || !trig[i]));
        // R5: a set command on an edge-sensed source sets pending
        a_r5_cmd_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (trig[i] && cmd_set[i]) |=> (pend[i] || !trig[i]));
        // R12: an edge event wins over a simultaneous clear
        a_r12_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (trig[i] && dual[i] && sync2[i] != prev[i]) |=> (pend[i] || !trig[i]));
    end

endmodule

// File: rtl/shirq_regs.sv
// Module: shirq_regs
// Register port: configuration bits, enable set/clear, pending command,
// route words and registered readback. Assumes one access per cycle.
module shirq_regs
    import shirq_pkg::*;
#(
    parameter int NUM_SRC = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] pol,
    output logic [NUM_SRC-1:0] trig,
    output logic [NUM_SRC-1:0] dual,
    output logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] cmd_set,
    output logic [NUM_SRC-1:0] cmd_clr,
    output route_t             route [NUM_SRC]
);

    logic [8:0]         rgn;
    logic [4:0]         wsel;
    logic [NUM_SRC-1:0] set_p, clr_p;
    logic [31:0]        rd_val;

    // Returns word w of a bit-per-source vector, zero-filled above NUM_SRC
    function automatic logic [31:0] pick_word(input logic [NUM_SRC-1:0] v,
                                              input logic [4:0] w);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (i / 32 == int'(w)) r[i % 32] = v[i];
        return r;
    endfunction

    // Split the word address into region and word select
    always_comb begin
        rgn  = reg_addr[13:5];
        wsel = reg_addr[4:0];
    end

    // Write pulses for enable set/clear and the pending command
    always_comb begin
        set_p   = '0;
        clr_p   = '0;
        cmd_set = '0;
        cmd_clr = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (reg_wr && (i / 32 == int'(wsel))) begin
                if (rgn == RGN_SMASK) set_p[i] = reg_wdata[i % 32];
                if (rgn == RGN_CMASK) clr_p[i] = reg_wdata[i % 32];
            end
            if (reg_wr && rgn == RGN_CMD && wsel == 5'd0 && reg_wdata[7:0] == 8'(i)) begin
                cmd_set[i] = reg_wdata[31];
                cmd_clr[i] = ~reg_wdata[31];
            end
        end
    end

    // Configuration, enable and route storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol  <= '1;
            trig <= '0;
            dual <= '0;
            mask <= '0;
            for (int i = 0; i < NUM_SRC; i++) route[i] <= '0;
        end else begin
            mask <= (mask | set_p) & ~clr_p;
            if (reg_wr) begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (i / 32 == int'(wsel)) begin
                        case (rgn)
                            RGN_POL:  pol[i]  <= reg_wdata[i % 32];
                            RGN_TRIG: trig[i] <= reg_wdata[i % 32];
                            RGN_DUAL: dual[i] <= reg_wdata[i % 32];
                            default: ;
                        endcase
                    end
                    if (reg_addr == ROUTE_BASE + 14'(i))
                        route[i] <= '{to_pin: reg_wdata[31], to_nmi: reg_wdata[30],
                                      pin: reg_wdata[PIN_FIELD_W-1:0]};
                end
            end
        end
    end

    // Read multiplexer
    always_comb begin
        case (rgn)
            RGN_POL:  rd_val = pick_word(pol, wsel);
            RGN_TRIG: rd_val = pick_word(trig, wsel);
            RGN_DUAL: rd_val = pick_word(dual, wsel);
            RGN_MASK: rd_val = pick_word(mask, wsel);
            RGN_PEND: rd_val = pick_word(pend, wsel);
            default:  rd_val = '0;
        endcase
        for (int i = 0; i < NUM_SRC; i++)
            if (reg_addr == ROUTE_BASE + 14'(i))
                rd_val = {route[i].to_pin, route[i].to_nmi,
                          {(30 - PIN_FIELD_W){1'b0}}, route[i].pin};
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_val;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        // R6: a set pulse enables the source
        a_r6_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
            set_p[i] |=> mask[i]);
        // R6: a clear pulse disables the source
        a_r6_clr_disables: assert property (@(posedge clk) disable iff (!rst_n)
            clr_p[i] |=> !mask[i]);
        // R6: without a pulse the enable bit does not move
        a_r6_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_p[i] && !clr_p[i]) |=> $stable(mask[i]));
    end

endmodule

// File: rtl/shirq_route.sv
// Module: shirq_route
// Combines pending and enable per source and drives registered pin/NMI
// outputs. Assumes pin numbers >= NUM_PINS simply match no pin.
module shirq_route
    import shirq_pkg::*;
#(
    parameter int NUM_SRC  = 48,
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  pend,
    input  logic [NUM_SRC-1:0]  mask,
    input  route_t              route [NUM_SRC],
    output logic [NUM_PINS-1:0] cpu_pin,
    output logic                nmi_out
);

    logic [NUM_SRC-1:0]  armed, nmi_sel;
    logic [NUM_PINS-1:0] pin_hit;

    // Sources that may drive an output
    always_comb begin
        armed = pend & mask;
        for (int i = 0; i < NUM_SRC; i++) nmi_sel[i] = route[i].to_nmi;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic any_p;
        // OR of every armed source routed to pin p
        always_comb begin
            any_p = 1'b0;
            for (int i = 0; i < NUM_SRC; i++)
                if (armed[i] && route[i].to_pin && route[i].pin == PIN_FIELD_W'(p))
                    any_p = 1'b1;
        end
        assign pin_hit[p] = any_p;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_pin <= '0;
            nmi_out <= 1'b0;
        end else begin
            cpu_pin <= pin_hit;
            nmi_out <= |(armed & nmi_sel);
        end
    end

    // R10: nothing armed means quiet outputs one cycle later
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (~|armed) |=> (cpu_pin == '0 && !nmi_out));
    // R10: an armed NMI-routed source raises NMI one cycle later
    a_r10_nmi_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (|(armed & nmi_sel)) |=> nmi_out);

endmodule

// File: rtl/shirq_top.sv
// Module: shirq_top
// Shared interrupt front end: conditioning, enable masking and routing.
// Assumes NUM_SRC <= 256 and NUM_PINS <= 64; irq_in is asynchronous.
module shirq_top
    import shirq_pkg::*;
#(
    parameter int NUM_SRC  = 48,
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  irq_in,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [13:0]         reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [NUM_PINS-1:0] cpu_pin,
    output logic                nmi_out
);

    logic [NUM_SRC-1:0] pol, trig, dual, mask, pend, cmd_set, cmd_clr;
    route_t             route [NUM_SRC];

    shirq_regs #(.NUM_SRC(NUM_SRC)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pend(pend), .pol(pol), .trig(trig), .dual(dual), .mask(mask),
        .cmd_set(cmd_set), .cmd_clr(cmd_clr), .route(route)
    );

    shirq_cond #(.NUM_SRC(NUM_SRC)) i_cond (
        .clk(clk), .rst_n(rst_n), .irq_raw(irq_in), .pol(pol), .trig(trig),
        .dual(dual), .cmd_set(cmd_set), .cmd_clr(cmd_clr), .pend(pend)
    );

    shirq_route #(.NUM_SRC(NUM_SRC), .NUM_PINS(NUM_PINS)) i_route (
        .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask), .route(route),
        .cpu_pin(cpu_pin), .nmi_out(nmi_out)
    );

endmodule

// File: tb/test_shirq_top.sv
`timescale 1ns/1ps
module test_shirq_top;

    localparam int N = 48;
    localparam int P = 8;
    localparam logic [13:0] A_POL   = 14'h040;
    localparam logic [13:0] A_TRIG  = 14'h060;
    localparam logic [13:0] A_DUAL  = 14'h080;
    localparam logic [13:0] A_CMD   = 14'h0A0;
    localparam logic [13:0] A_CMASK = 14'h0C0;
    localparam logic [13:0] A_SMASK = 14'h0E0;
    localparam logic [13:0] A_MASK  = 14'h100;
    localparam logic [13:0] A_PEND  = 14'h120;
    localparam logic [13:0] A_ROUTE = 14'h140;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq = '0;
    logic         reg_wr = 1'b0;
    logic         reg_rd = 1'b0;
    logic [13:0]  reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [P-1:0] cpu_pin;
    logic         nmi_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    shirq_top #(.NUM_SRC(N), .NUM_PINS(P)) i_shirq_top (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_pin(cpu_pin), .nmi_out(nmi_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(posedge clk);
        #1 reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [13:0] a,
                          input logic [31:0] m, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(tag, d & m, exp);
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        check("R1 pins", 32'(cpu_pin), 32'h0);
        check("R1 nmi", 32'(nmi_out), 32'h0);
        rd_chk("R1 pol w0", A_POL, '1, 32'hFFFF_FFFF);
        rd_chk("R1 R8 pol w1 upper zero", A_POL + 14'd1, '1, 32'h0000_FFFF);
        rd_chk("R1 trig", A_TRIG, '1, 32'h0);
        rd_chk("R1 dual", A_DUAL + 14'd1, '1, 32'h0);
        rd_chk("R1 mask", A_MASK, '1, 32'h0);
        rd_chk("R1 pend", A_PEND + 14'd1, '1, 32'h0);
        rd_chk("R1 route", A_ROUTE + 14'd7, '1, 32'h0);
    endtask

    task automatic t_readback();
        wr(A_TRIG + 14'd1, 32'hFFFF_FFFF);
        rd_chk("R8 trig w1", A_TRIG + 14'd1, '1, 32'h0000_FFFF);
        wr(A_DUAL, 32'hA5A5_A5A5);
        rd_chk("R8 dual w0", A_DUAL, '1, 32'hA5A5_A5A5);
        wr(A_ROUTE + 14'd3, 32'hFFFF_FFFF);
        rd_chk("R9 route bits", A_ROUTE + 14'd3, '1, 32'hC000_003F);
        rd_chk("R7 cmd reads zero", A_CMD, '1, 32'h0);
        rd_chk("R7 smask reads zero", A_SMASK, '1, 32'h0);
        wr(A_TRIG + 14'd1, 32'h0);
        wr(A_DUAL, 32'h0);
        wr(A_ROUTE + 14'd3, 32'h0);
    endtask

    task automatic t_mask();
        wr(A_SMASK, 32'h0000_000F);
        rd_chk("R6 set", A_MASK, '1, 32'h0000_000F);
        wr(A_SMASK, 32'h0);
        wr(A_CMASK, 32'h0);
        rd_chk("R6 zero writes no effect", A_MASK, '1, 32'h0000_000F);
        wr(A_CMASK, 32'h0000_0005);
        rd_chk("R6 clear", A_MASK, '1, 32'h0000_000A);
        wr(A_SMASK + 14'd1, 32'h0000_0100);
        rd_chk("R6 word1", A_MASK + 14'd1, '1, 32'h0000_0100);
        wr(A_CMASK, 32'hFFFF_FFFF);
        wr(A_CMASK + 14'd1, 32'hFFFF_FFFF);
        rd_chk("R6 all clear", A_MASK + 14'd1, '1, 32'h0);
    endtask

    task automatic t_level();
        wr(A_SMASK, 32'h1);
        wr(A_ROUTE + 14'd0, 32'h8000_0002);
        irq[0] = 1'b1;
        settle();
        rd_chk("R2 active high pend", A_PEND, 32'h1, 32'h1);
        check("R2 pin", 32'(cpu_pin), 32'h4);
        wr(A_POL, 32'hFFFF_FFFE);
        settle();
        rd_chk("R2 active low, input high", A_PEND, 32'h1, 32'h0);
        check("R2 pin dropped", 32'(cpu_pin), 32'h0);
        irq[0] = 1'b0;
        settle();
        rd_chk("R2 active low, input low", A_PEND, 32'h1, 32'h1);
        wr(A_POL, 32'hFFFF_FFFF);
        settle();
        wr(A_CMD, 32'h8000_0000);
        settle();
        rd_chk("R5 cmd ignored on level source", A_PEND, 32'h1, 32'h0);
        wr(A_CMASK, 32'h1);
        wr(A_ROUTE + 14'd0, 32'h0);
    endtask

    task automatic t_latency();
        wr(A_SMASK, 32'h2);
        wr(A_ROUTE + 14'd1, 32'h8000_0005);
        settle();
        check("R11 pin low before", 32'(cpu_pin), 32'h0);
        @(negedge clk);
        irq[1] = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R11 not after three edges", 32'(cpu_pin), 32'h0);
        @(posedge clk);
        #1 check("R11 after four edges", 32'(cpu_pin), 32'h20);
        irq[1] = 1'b0;
        settle();
        wr(A_CMASK, 32'h2);
        wr(A_ROUTE + 14'd1, 32'h0);
    endtask

    task automatic t_edge();
        wr(A_TRIG + 14'd1, 32'h100);
        wr(A_SMASK + 14'd1, 32'h100);
        wr(A_ROUTE + 14'd40, 32'h8000_0007);
        irq[40] = 1'b1;
        settle();
        rd_chk("R3 rising sets", A_PEND + 14'd1, 32'h100, 32'h100);
        check("R3 pin7", 32'(cpu_pin), 32'h80);
        irq[40] = 1'b0;
        settle();
        rd_chk("R3 held after input drops", A_PEND + 14'd1, 32'h100, 32'h100);
        wr(A_CMD, 32'h0000_0028);
        settle();
        rd_chk("R5 clear command", A_PEND + 14'd1, 32'h100, 32'h0);
        check("R3 pin cleared", 32'(cpu_pin), 32'h0);
        wr(A_POL + 14'd1, 32'h0000_FEFF);
        settle();
        irq[40] = 1'b1;
        settle();
        rd_chk("R3 rising ignored when falling selected", A_PEND + 14'd1, 32'h100, 32'h0);
        irq[40] = 1'b0;
        settle();
        rd_chk("R3 falling sets", A_PEND + 14'd1, 32'h100, 32'h100);
        wr(A_CMD, 32'h0000_0028);
        wr(A_POL + 14'd1, 32'hFFFF_FFFF);
        settle();
    endtask

    task automatic t_dual();
        wr(A_DUAL + 14'd1, 32'h100);
        irq[40] = 1'b1;
        settle();
        rd_chk("R4 dual rising", A_PEND + 14'd1, 32'h100, 32'h100);
        wr(A_CMD, 32'h0000_0028);
        settle();
        irq[40] = 1'b0;
        settle();
        rd_chk("R4 dual falling", A_PEND + 14'd1, 32'h100, 32'h100);
        wr(A_CMD, 32'h0000_0028);
        wr(A_DUAL + 14'd1, 32'h300);
        irq[41] = 1'b1;
        settle();
        rd_chk("R4 level with dual follows high", A_PEND + 14'd1, 32'h200, 32'h200);
        irq[41] = 1'b0;
        settle();
        rd_chk("R4 level with dual no latch", A_PEND + 14'd1, 32'h200, 32'h0);
        wr(A_DUAL + 14'd1, 32'h0);
    endtask

    task automatic t_cmd();
        wr(A_CMD, 32'h8000_0028);
        settle();
        rd_chk("R5 set command", A_PEND + 14'd1, 32'h100, 32'h100);
        wr(A_CMD, 32'h0000_0028);
        settle();
        rd_chk("R5 clear command", A_PEND + 14'd1, 32'h100, 32'h0);
        wr(A_CMD, 32'h8000_0030);
        wr(A_CMD, 32'h8000_00FF);
        settle();
        rd_chk("R5 out-of-range w0", A_PEND, '1, 32'h0);
        rd_chk("R5 out-of-range w1", A_PEND + 14'd1, '1, 32'h0);
    endtask

    task automatic t_route();
        wr(A_SMASK, 32'hC);
        wr(A_ROUTE + 14'd2, 32'h4000_0000);
        irq[2] = 1'b1;
        settle();
        check("R10 nmi only", 32'(nmi_out), 32'h1);
        check("R10 no pin", 32'(cpu_pin), 32'h0);
        wr(A_ROUTE + 14'd2, 32'hC000_0003);
        settle();
        check("R10 both pin", 32'(cpu_pin), 32'h8);
        check("R10 both nmi", 32'(nmi_out), 32'h1);
        wr(A_ROUTE + 14'd2, 32'h8000_0009);
        settle();
        check("R10 pin out of range", 32'(cpu_pin), 32'h0);
        check("R10 nmi off", 32'(nmi_out), 32'h0);
        wr(A_ROUTE + 14'd2, 32'h8000_0001);
        wr(A_ROUTE + 14'd3, 32'h8000_0001);
        irq[3] = 1'b1;
        settle();
        check("R10 shared pin", 32'(cpu_pin), 32'h2);
        wr(A_CMASK, 32'h4);
        settle();
        check("R10 one source left", 32'(cpu_pin), 32'h2);
        wr(A_CMASK, 32'h8);
        settle();
        check("R10 all disabled", 32'(cpu_pin), 32'h0);
        irq[2] = 1'b0;
        irq[3] = 1'b0;
        wr(A_ROUTE + 14'd2, 32'h0);
        wr(A_ROUTE + 14'd3, 32'h0);
    endtask

    task automatic t_race();
        wr(A_TRIG + 14'd1, 32'h100);
        wr(A_CMD, 32'h0000_0028);
        settle();
        rd_chk("R12 precondition", A_PEND + 14'd1, 32'h100, 32'h0);
        @(negedge clk);
        irq[40] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_addr = A_CMD; reg_wdata = 32'h0000_0028; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
        settle();
        rd_chk("R12 event beats clear", A_PEND + 14'd1, 32'h100, 32'h100);
        irq[40] = 1'b0;
        wr(A_CMD, 32'h0000_0028);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_readback();
        t_mask();
        t_level();
        t_latency();
        t_edge();
        t_dual();
        t_cmd();
        t_route();
        t_race();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule